// File: doc/BRIEF.md
# Fault Hiccup Restart Gate

This block decides, for every power-on attempt of a switching controller, whether that attempt may drive the power switch. A power-on attempt starts each time the supply rail reaches its start threshold. Upstream logic reports this as a one-cycle `start_evt` pulse. With no fault recorded, every attempt is granted, so the controller simply restarts each time.

A qualifying fault arms a duty-cycled restart pattern. Examples are an output short or an undervoltage shutdown while in constant-current mode. Each fault source has its own bit on `fault_in`. While the pattern is armed, the attempts are numbered in a modulo-8 slot sequence. Slots 0 and 1 are granted and slots 2 to 7 are blocked. The sequence then wraps, and this continues for as long as the fault persists. This cuts the average power delivered into a persistent fault by a factor of four.

The pattern is cleared when the fault has gone away. A granted attempt must report soft-start completion on `ss_done` and then run for `CLEAN_CYCLES` clock cycles with no fault and no new start event. A `bypass` input turns the pattern off for variants that want plain auto-restart. The grant is registered. It changes only when a start event is taken, and holds for the whole attempt.

Top module: `hiccup_gate`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `permit` and `pattern_active` are both 0.
- R2: While `pattern_active` is 0, every `start_evt` pulse sets `permit` to 1 at the next clock edge.
- R3: A high bit on any line of `fault_in`, with `bypass` low, sets `pattern_active` at the next edge. When the pattern was not already active, the slot sequence restarts at slot 0. The next two start events are granted (`permit`=1) and the six after them are blocked (`permit`=0).
- R4: While the pattern stays active, the grant sequence repeats with period 8. Start events at slot positions 0 and 1 (mod 8) are granted, and positions 2 to 7 are blocked.
- R5: A fault reported while the pattern is already active does not move the slot position.
- R6: After `ss_done` arrives during a granted attempt, `CLEAN_CYCLES` consecutive cycles with no fault and no start event clear `pattern_active` at the edge that ends the last of them. A start event after that is granted.
- R7: The clean window is aborted by a fault or a new start event, which keeps the pattern active. `ss_done` during a blocked attempt does not open a clean window.
- R8: While `bypass` is high, every start event is granted. `pattern_active` reads 0 from the next edge on, and faults do not arm the pattern.
- R9: `permit` changes only at the edge that samples a `start_evt` pulse (or reset). Faults, `ss_done` and `bypass` alone leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle pulse: supply rail reached the start threshold |
| fault_in | input | NUM_FLT | Per-source qualifying fault indications (any bit high counts) |
| ss_done | input | 1 | One-cycle pulse: soft-start of the current attempt completed |
| bypass | input | 1 | Forces plain auto-restart and holds the pattern off |
| permit | output | 1 | Registered grant for the current power-on attempt |
| pattern_active | output | 1 | The restart pattern is armed |

## Verification
The hardest state to reach is a clean window that reaches its last cycle. The window only opens during a granted attempt, after `ss_done`, and only while the pattern is armed. So the stimulus first arms the pattern with a fault. It then steps start events until a granted slot is reached, which it detects from `permit` at the ports. It delivers `ss_done` and waits through the window. Variants of that sequence inject a fault, a new start, or an `ss_done` on a blocked slot part way through, to show the window is aborted. A behavioural model tracks slot position and window progress as plain integers and is compared with both outputs on every clock.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  // Default policy: grant the first ALLOW slots of every PERIOD-slot round.
  localparam int unsigned DEF_PERIOD = 8;
  localparam int unsigned DEF_ALLOW  = 2;
  localparam int unsigned DEF_CLEAN  = 1000;
  localparam int unsigned DEF_NFLT   = 2;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_RUN  = 2'd1
  } win_state_t;
endpackage

// File: rtl/fault_or.sv
module fault_or #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] flt,
  output logic         any
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | flt[i];
  end
  assign any = chain[N];
endmodule

// File: rtl/slot_seq.sv
module slot_seq #(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned ALLOW  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fault_any,
  input  logic clean,
  input  logic bypass,
  output logic active,
  output logic grant
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(PERIOD - 1);
  localparam logic [CW-1:0] ALLOW_W   = CW'(ALLOW);

  logic          active_q;
  logic [CW-1:0] slot_q;

  // Grant for an attempt that starts this cycle.
  assign grant  = bypass | ~active_q | (slot_q < ALLOW_W);
  assign active = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      slot_q   <= '0;
    end else if (bypass) begin
      active_q <= 1'b0;
      slot_q   <= '0;
    end else if (fault_any) begin
      if (!active_q) begin
        active_q <= 1'b1;
        slot_q   <= '0;
      end else if (start) begin
        slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
    end else if (clean) begin
      active_q <= 1'b0;
      slot_q   <= '0;
    end else if (start && active_q) begin
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end
endmodule

// File: rtl/clean_timer.sv
module clean_timer
  import hiccup_pkg::*;
#(
  parameter int unsigned CLEAN_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fault_any,
  input  logic ss_done,
  input  logic permit,
  output logic clean
);
  localparam int unsigned TW = $clog2(CLEAN_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(CLEAN_CYCLES - 1);

  win_state_t     st_q;
  logic [TW-1:0]  cnt_q;

  assign clean = (st_q == WIN_RUN) && (cnt_q == LAST) && !fault_any && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else if (fault_any || start) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else if (clean) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else if (ss_done && permit) begin
      st_q  <= WIN_RUN;
      cnt_q <= '0;
    end else if (st_q == WIN_RUN) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hiccup_gate.sv
module hiccup_gate
  import hiccup_pkg::*;
#(
  parameter int unsigned PERIOD       = DEF_PERIOD,
  parameter int unsigned ALLOW        = DEF_ALLOW,
  parameter int unsigned CLEAN_CYCLES = DEF_CLEAN,
  parameter int unsigned NUM_FLT      = DEF_NFLT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_evt,
  input  logic [NUM_FLT-1:0] fault_in,
  input  logic               ss_done,
  input  logic               bypass,
  output logic               permit,
  output logic               pattern_active
);
  logic fault_any;
  logic grant;
  logic clean;
  logic permit_q;

  fault_or #(.N(NUM_FLT)) u_for (
    .flt (fault_in),
    .any (fault_any)
  );

  slot_seq #(.PERIOD(PERIOD), .ALLOW(ALLOW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_evt),
    .fault_any (fault_any),
    .clean     (clean),
    .bypass    (bypass),
    .active    (pattern_active),
    .grant     (grant)
  );

  clean_timer #(.CLEAN_CYCLES(CLEAN_CYCLES)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .start     (start_evt),
    .fault_any (fault_any),
    .ss_done   (ss_done),
    .permit    (permit_q),
    .clean     (clean)
  );

  // Grant is latched at each start and held for the attempt.
  always_ff @(posedge clk) begin
    if (rst)            permit_q <= 1'b0;
    else if (start_evt) permit_q <= grant;
  end

  assign permit = permit_q;
endmodule

// File: rtl/hiccup_gate_sva.sv
module hiccup_gate_sva #(
  parameter int unsigned NUM_FLT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start_evt,
  input logic [NUM_FLT-1:0] fault_in,
  input logic               bypass,
  input logic               permit,
  input logic               pattern_active
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!permit && !pattern_active));

  p_idle_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !pattern_active) |=> permit);

  p_arm_r3: assert property (@(posedge clk) disable iff (rst)
    ((|fault_in) && !bypass) |=> pattern_active);

  p_bypass_grant_r8: assert property (@(posedge clk) disable iff (rst)
    (start_evt && bypass) |=> permit);

  p_bypass_clear_r8: assert property (@(posedge clk) disable iff (rst)
    bypass |=> !pattern_active);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> $stable(permit));
endmodule

bind hiccup_gate hiccup_gate_sva #(.NUM_FLT(NUM_FLT)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .start_evt      (start_evt),
  .fault_in       (fault_in),
  .bypass         (bypass),
  .permit         (permit),
  .pattern_active (pattern_active)
);

// File: tb/sim_hiccup_gate.sv
`timescale 1ns/1ps
module sim_hiccup_gate;
  localparam int CLEAN = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_evt = 1'b0;
  logic [1:0] fault_in = 2'b00;
  logic       ss_done = 1'b0;
  logic       bypass = 1'b0;
  logic       permit;
  logic       pattern_active;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  hiccup_gate #(.PERIOD(8), .ALLOW(2), .CLEAN_CYCLES(CLEAN), .NUM_FLT(2)) u0 (
    .clk(clk), .rst(rst), .start_evt(start_evt), .fault_in(fault_in),
    .ss_done(ss_done), .bypass(bypass), .permit(permit),
    .pattern_active(pattern_active)
  );

  // Behavioural reference model
  int m_perm = 0, m_act = 0, m_pos = 0, m_run = 0, m_cnt = 0;

  always @(posedge clk) begin
    int flt, cln, n_perm, n_act, n_pos, n_run, n_cnt;
    if (rst) begin
      m_perm = 0; m_act = 0; m_pos = 0; m_run = 0; m_cnt = 0;
    end else begin
      flt = (fault_in != 0);
      n_perm = m_perm; n_act = m_act; n_pos = m_pos; n_run = m_run; n_cnt = m_cnt;
      if (start_evt) n_perm = (bypass || !m_act || (m_pos < 2)) ? 1 : 0;
      cln = (m_run && m_cnt == CLEAN - 1 && !flt && !start_evt);
      if (bypass) begin n_act = 0; n_pos = 0; end
      else begin
        if (start_evt && m_act) n_pos = (m_pos + 1) % 8;
        if (flt && !m_act) begin n_act = 1; n_pos = 0; end
        else if (cln) begin n_act = 0; n_pos = 0; end
      end
      if (flt || start_evt) begin n_run = 0; n_cnt = 0; end
      else if (cln) begin n_run = 0; n_cnt = 0; end
      else if (ss_done && m_perm) begin n_run = 1; n_cnt = 0; end
      else if (m_run) n_cnt = m_cnt + 1;
      m_perm = n_perm; m_act = n_act; m_pos = n_pos; m_run = n_run; m_cnt = n_cnt;
    end
    #1;
    if (!rst) begin
      checks++;
      if (permit !== m_perm[0] || pattern_active !== m_act[0]) begin
        fails++;
        $display("FAIL %s model compare: permit=%0b active=%0b expected permit=%0d active=%0d",
                 tag, permit, pattern_active, m_perm, m_act);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
  endtask

  task automatic do_fault(input logic [1:0] f);
    @(negedge clk) fault_in = f;
    @(negedge clk) fault_in = 2'b00;
  endtask

  task automatic do_ss();
    @(negedge clk) ss_done = 1'b1;
    @(negedge clk) ss_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_granted();
    for (int k = 0; k < 9; k++) begin
      do_start();
      if (permit) break;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic held;
    repeat (3) @(negedge clk);
    chk("R1", permit, 1'b0, "permit in reset");
    chk("R1", pattern_active, 1'b0, "active in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", permit, 1'b0, "permit after reset");

    tag = "R2";
    for (int i = 0; i < 3; i++) begin
      do_start();
      chk("R2", permit, 1'b1, "plain auto-restart grant");
    end

    tag = "R3";
    do_fault(2'b10);
    chk("R3", pattern_active, 1'b1, "pattern armed by fault");
    for (int i = 0; i < 16; i++) begin
      do_start();
      chk((i < 8) ? "R3" : "R4", permit, ((i % 8) < 2) ? 1'b1 : 1'b0, "slot grant");
    end

    tag = "R5";
    do_start(); do_start(); do_start();
    chk("R5", permit, 1'b0, "slot 2 blocked");
    do_fault(2'b01);
    for (int i = 0; i < 5; i++) begin
      do_start();
      chk("R5", permit, 1'b0, "fault did not reset slot");
    end
    do_start();
    chk("R5", permit, 1'b1, "wrap to slot 0");

    tag = "R6";
    do_ss();
    idle(CLEAN + 2);
    chk("R6", pattern_active, 1'b0, "cleared after clean window");
    do_start();
    chk("R6", permit, 1'b1, "grant after clear");

    tag = "R7";
    do_fault(2'b01);
    to_granted();
    do_ss(); idle(8); do_fault(2'b10); idle(CLEAN + 5);
    chk("R7", pattern_active, 1'b1, "fault aborts clean window");
    to_granted();
    do_ss(); idle(8); do_start(); idle(CLEAN + 5);
    chk("R7", pattern_active, 1'b1, "start aborts clean window");
    for (int k = 0; k < 9; k++) begin
      do_start();
      if (!permit) break;
    end
    chk("R7", permit, 1'b0, "reached blocked slot");
    do_ss(); idle(CLEAN + 5);
    chk("R7", pattern_active, 1'b1, "ss_done on blocked slot ignored");

    tag = "R9";
    held = permit;
    do_fault(2'b11); do_ss(); idle(4);
    chk("R9", permit, held, "permit held without start");

    tag = "R8";
    @(negedge clk) bypass = 1'b1;
    @(negedge clk);
    chk("R8", pattern_active, 1'b0, "bypass clears pattern");
    for (int i = 0; i < 4; i++) begin
      do_fault(2'b01);
      do_start();
      chk("R8", permit, 1'b1, "bypass grant");
      chk("R8", pattern_active, 1'b0, "fault ignored under bypass");
    end
    @(negedge clk) bypass = 1'b0;
    do_start();
    chk("R2", permit, 1'b1, "grant after bypass release");
    idle(3);
    finish_run();
  end
endmodule